// File: doc/BRIEF.md
# Serial Bus Packet Receive Filter

This block sits between the quadlet stream coming up from a serial-bus physical layer and the write side of a general receive FIFO. It looks at the first quadlet of each packet and decides whether the packet is meant for this node. An accepted packet has its header protected by a CRC-32. The header quadlets are written into the FIFO as they arrive, but the packet is made visible to the FIFO reader only once the whole packet has been checked. If the header CRC is bad, or the FIFO runs out of room, the written quadlets are withdrawn and the rest of the packet is skipped.

The block and isochronous packets carry a payload. The payload is stored one quadlet at a time and has a data CRC of its own. After the last stored quadlet, the block appends one status quadlet holding an acknowledge-style code. That code reports whether the data CRC was good, and broadcast packets get it as well. When a cycle-start packet passes its header check, the block also sends its timer quadlet to the cycle timer on a side channel. The packet itself is still stored like any other quadlet packet.

The FIFO write pointer lives in this block. The reader sees the committed pointer `fifo_commit_ptr` and returns its own read pointer on `fifo_rd_ptr`. Both pointers carry one wrap bit above the address.

The control is a single state machine with six states:
- **IDLE** waits for a start-of-packet quadlet. It leaves for **HDR** (multi-quadlet header) or **HCRC** (one-quadlet header).
- **HDR** collects the header quadlets. It leaves for **HCRC** after the last one, or for **IDLE** on FIFO full.
- **HCRC** checks the header CRC. It leaves for **DATA** (payload present), for **STATUS** (no payload) or for **IDLE** (bad CRC).
- **DATA** stores the payload. It leaves for **DCRC** after the last payload quadlet, or for **IDLE** on FIFO full.
- **DCRC** checks the data CRC and leaves for **STATUS**.
- **STATUS** writes the status quadlet and commits the packet, then returns to **IDLE**.

Top module: `pkt_rx_filter`

## Requirements
- R1: Quadlet 0 bits [31:16] hold the destination. An asynchronous packet is accepted only if that destination equals `node_id` or 16'hFFFF. A rejected packet leaves `fifo_commit_ptr` unchanged. Isochronous packets (type 4'hA) are always accepted.
- R2: The packet type is quadlet 0 bits [7:4]. Type 4'h1 has 4 header quadlets, a header CRC quadlet, a payload and a data CRC quadlet. Type 4'hA has 1 header quadlet, a header CRC quadlet, a payload and a data CRC quadlet. Every other type has 4 header quadlets and a header CRC quadlet only.
- R3: The header CRC is CRC-32 with polynomial 04C11DB7 and an all-ones start value. It runs over the header quadlets, most significant bit first, and the CRC quadlet must equal the bitwise inverse of the result. On a mismatch nothing of the packet is committed, and all of its remaining quadlets are ignored.
- R4: A stored packet occupies consecutive FIFO addresses starting at the committed pointer. The header quadlets come first, then the payload quadlets. Neither CRC quadlet is stored.
- R5: The payload length in bytes is bits [31:16] of the last header quadlet. The payload quadlet count is that length divided by 4, rounded up. A length of zero means no payload and no data CRC quadlet.
- R6: One status quadlet follows the stored packet. Bits [31:4] are zero. Bits [3:0] are 4'h1 when the data CRC is good or there is no payload, and 4'hD when the data CRC is bad. Broadcast packets follow the same rule.
- R7: `fifo_commit_ptr` advances by the stored quadlet count (header + payload + 1) in the cycle after the status write, and at no other time.
- R8: If the FIFO is full when a quadlet of an accepted packet must be written, the write pointer returns to the committed pointer. Nothing of that packet is committed, and the FIFO never holds more than its depth.
- R9: A type 4'h8 packet that passes R1 and R3 raises `cyc_valid` for exactly one cycle, one cycle after its header CRC quadlet. At that point `cyc_time` holds its fourth header quadlet. A bad header CRC raises no pulse.
- R10: After reset, `fifo_commit_ptr` is 0, and both `fifo_wr_en` and `cyc_valid` are low.
- R11: In IDLE, quadlets without `rx_sop` cause no FIFO write. A low `rx_valid` stalls the packet without losing its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| node_id | input | 16 | This node's bus/physical identifier |
| rx_valid | input | 1 | Quadlet on `rx_data` is valid |
| rx_sop | input | 1 | Quadlet is the first of a packet |
| rx_data | input | 32 | Received quadlet |
| fifo_rd_ptr | input | AW+1 | FIFO reader's pointer with wrap bit |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_addr | output | AW | FIFO write address |
| fifo_wr_data | output | 32 | FIFO write quadlet |
| fifo_commit_ptr | output | AW+1 | End of the last committed packet, with wrap bit |
| cyc_valid | output | 1 | One-cycle strobe: cycle timer data valid |
| cyc_time | output | 32 | Timer quadlet from the last good cycle-start packet |

## Verification
The assertions assume the FIFO reader never moves its pointer past `fifo_commit_ptr`. They also assume that `rx_sop` arrives only between packets, with at least one cycle without `rx_valid` after a packet's last quadlet. The stimulus keeps to both rules. After each packet and its trailing idle cycles, the read pointer is moved to the committed pointer. The full case places the read pointer a legal distance behind the committed pointer. Random packets take stall cycles only between their quadlets, and each packet is followed by three idle cycles.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_HCRC,
        ST_DATA,
        ST_DCRC,
        ST_STATUS
    } rx_state_e;

    localparam int          LEN_W     = 16;
    localparam int          CNT_W     = LEN_W - 1;
    localparam logic [3:0]  TC_BLOCK  = 4'h1;
    localparam logic [3:0]  TC_CYCLE  = 4'h8;
    localparam logic [3:0]  TC_ISO    = 4'hA;
    localparam logic [3:0]  ACK_DONE  = 4'h1;
    localparam logic [3:0]  ACK_DERR  = 4'hD;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT  = 32'hFFFF_FFFF;
    localparam logic [15:0] BCAST_ID  = 16'hFFFF;

endpackage

// File: rtl/pkt_rx_crc32.sv
module pkt_rx_crc32
    import pkt_rx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [31:0]   crc_in,
    input  logic [DW-1:0] data,
    output logic [31:0]   crc_out
);

    logic [31:0] acc;

    // one full quadlet per cycle, most significant bit first
    always_comb begin
        acc = crc_in;
        for (int b = DW - 1; b >= 0; b--) begin
            if (acc[31] ^ data[b]) begin
                acc = {acc[30:0], 1'b0} ^ CRC_POLY;
            end else begin
                acc = {acc[30:0], 1'b0};
            end
        end
        crc_out = acc;
    end

endmodule

// File: rtl/pkt_rx_decode.sv
module pkt_rx_decode
    import pkt_rx_pkg::*;
(
    input  logic [31:0] first_q,
    input  logic [15:0] node_id,
    output logic [2:0]  hdr_len,
    output logic        has_payload,
    output logic        is_cycle,
    output logic        accept
);

    logic [3:0]  tcode;
    logic [15:0] dest;

    always_comb begin
        tcode       = first_q[7:4];
        dest        = first_q[31:16];
        hdr_len     = (tcode == TC_ISO) ? 3'd1 : 3'd4;
        has_payload = (tcode == TC_BLOCK) || (tcode == TC_ISO);
        is_cycle    = (tcode == TC_CYCLE);
        accept      = (tcode == TC_ISO) || (dest == node_id) || (dest == BCAST_ID);
    end

endmodule

// File: rtl/pkt_rx_filter.sv
module pkt_rx_filter
    import pkt_rx_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   node_id,
    input  logic          rx_valid,
    input  logic          rx_sop,
    input  logic [31:0]   rx_data,
    input  logic [AW:0]   fifo_rd_ptr,
    output logic          fifo_wr_en,
    output logic [AW-1:0] fifo_wr_addr,
    output logic [31:0]   fifo_wr_data,
    output logic [AW:0]   fifo_commit_ptr,
    output logic          cyc_valid,
    output logic [31:0]   cyc_time
);

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    rx_state_e        state_q, state_d;
    logic [PW-1:0]    wr_ptr_q, commit_q;
    logic [2:0]       hdr_cnt_q;
    logic [CNT_W-1:0] pay_cnt_q;
    logic [31:0]      crc_q, crc_seed, crc_nxt;
    logic [31:0]      last_q;
    logic             payload_q, cycle_q;
    logic [3:0]       code_q;
    logic             cyc_valid_q;
    logic [31:0]      cyc_time_q;

    logic [2:0]       dec_hdr_len;
    logic             dec_payload, dec_cycle, dec_accept;
    logic             full, crc_match, wr_en, drop;
    logic [31:0]      wr_data;
    logic [LEN_W:0]   len_round;
    logic [CNT_W-1:0] pay_quads;

    pkt_rx_decode u_decode (
        .first_q     (rx_data),
        .node_id     (node_id),
        .hdr_len     (dec_hdr_len),
        .has_payload (dec_payload),
        .is_cycle    (dec_cycle),
        .accept      (dec_accept)
    );

    pkt_rx_crc32 #(.DW(32)) u_crc (
        .crc_in  (crc_seed),
        .data    (rx_data),
        .crc_out (crc_nxt)
    );

    assign full      = (wr_ptr_q - fifo_rd_ptr) == PW'(DEPTH);
    assign crc_match = (rx_data == ~crc_q);
    assign len_round = {1'b0, last_q[31:16]} + (LEN_W+1)'(3);
    assign pay_quads = len_round[LEN_W:2];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and write-port outputs
    always_comb begin
        state_d  = state_q;
        wr_en    = 1'b0;
        drop     = 1'b0;
        wr_data  = rx_data;
        crc_seed = crc_q;
        unique case (state_q)
            ST_IDLE: begin
                crc_seed = CRC_INIT;
                if (rx_valid && rx_sop && dec_accept) begin
                    if (full) begin
                        drop = 1'b1;
                    end else begin
                        wr_en   = 1'b1;
                        state_d = (dec_hdr_len == 3'd1) ? ST_HCRC : ST_HDR;
                    end
                end
            end
            ST_HDR: begin
                if (rx_valid) begin
                    if (full) begin
                        drop    = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        wr_en = 1'b1;
                        if (hdr_cnt_q == 3'd1) state_d = ST_HCRC;
                    end
                end
            end
            ST_HCRC: begin
                if (rx_valid) begin
                    if (!crc_match) begin
                        drop    = 1'b1;
                        state_d = ST_IDLE;
                    end else if (payload_q && (pay_quads != '0)) begin
                        state_d = ST_DATA;
                    end else begin
                        state_d = ST_STATUS;
                    end
                end
            end
            ST_DATA: begin
                if (rx_valid) begin
                    if (full) begin
                        drop    = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        wr_en = 1'b1;
                        if (pay_cnt_q == CNT_W'(1)) state_d = ST_DCRC;
                    end
                end
            end
            ST_DCRC: begin
                if (rx_valid) state_d = ST_STATUS;
            end
            ST_STATUS: begin
                wr_data = {28'd0, code_q};
                if (full) begin
                    drop = 1'b1;
                end else begin
                    wr_en = 1'b1;
                end
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q    <= '0;
            commit_q    <= '0;
            hdr_cnt_q   <= '0;
            pay_cnt_q   <= '0;
            crc_q       <= CRC_INIT;
            last_q      <= '0;
            payload_q   <= 1'b0;
            cycle_q     <= 1'b0;
            code_q      <= ACK_DONE;
            cyc_valid_q <= 1'b0;
            cyc_time_q  <= '0;
        end else begin
            cyc_valid_q <= 1'b0;
            if (drop) begin
                wr_ptr_q <= commit_q;
            end else if (wr_en) begin
                wr_ptr_q <= wr_ptr_q + PW'(1);
            end
            if (wr_en && (state_q != ST_STATUS)) begin
                crc_q <= crc_nxt;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_en) begin
                        hdr_cnt_q <= dec_hdr_len - 3'd1;
                        payload_q <= dec_payload;
                        cycle_q   <= dec_cycle;
                        last_q    <= rx_data;
                    end
                end
                ST_HDR: begin
                    if (wr_en) begin
                        hdr_cnt_q <= hdr_cnt_q - 3'd1;
                        last_q    <= rx_data;
                    end
                end
                ST_HCRC: begin
                    if (rx_valid && crc_match) begin
                        crc_q     <= CRC_INIT;
                        pay_cnt_q <= pay_quads;
                        code_q    <= ACK_DONE;
                        if (cycle_q) begin
                            cyc_valid_q <= 1'b1;
                            cyc_time_q  <= last_q;
                        end
                    end
                end
                ST_DATA: begin
                    if (wr_en) pay_cnt_q <= pay_cnt_q - CNT_W'(1);
                end
                ST_DCRC: begin
                    if (rx_valid) code_q <= crc_match ? ACK_DONE : ACK_DERR;
                end
                ST_STATUS: begin
                    if (wr_en) commit_q <= wr_ptr_q + PW'(1);
                end
                default: ;
            endcase
        end
    end

    assign fifo_wr_en      = wr_en;
    assign fifo_wr_addr    = wr_ptr_q[AW-1:0];
    assign fifo_wr_data    = wr_data;
    assign fifo_commit_ptr = commit_q;
    assign cyc_valid       = cyc_valid_q;
    assign cyc_time        = cyc_time_q;

endmodule

// File: rtl/pkt_rx_filter_chk.sv
module pkt_rx_filter_chk
    import pkt_rx_pkg::*;
#(
    parameter int AW = 9
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_valid,
    input logic        fifo_wr_en,
    input logic [31:0] fifo_wr_data,
    input logic [AW:0] fifo_commit_ptr,
    input logic [AW:0] fifo_rd_ptr,
    input logic [AW:0] wr_ptr_q,
    input rx_state_e   state_q,
    input logic        cyc_valid
);

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] fill;
    assign fill = wr_ptr_q - fifo_rd_ptr;

    // R7: the committed pointer only moves right after a status write
    p_commit_after_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fifo_commit_ptr) |-> ($past(state_q) == ST_STATUS));

    // R8: never more than DEPTH quadlets outstanding
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PW'(DEPTH));

    // R9: cycle data strobe lasts one cycle
    p_cyc_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |=> !cyc_valid);

    // R6: status quadlet carries only a legal code
    p_status_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_en && (state_q == ST_STATUS)) |->
            ((fifo_wr_data[31:4] == 28'd0) &&
             ((fifo_wr_data[3:0] == ACK_DONE) || (fifo_wr_data[3:0] == ACK_DERR))));

    // R11: received quadlets are only written while one is presented
    p_write_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_en && (state_q != ST_STATUS)) |-> rx_valid);

endmodule

bind pkt_rx_filter pkt_rx_filter_chk #(.AW(AW)) u_pkt_rx_filter_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rx_valid        (rx_valid),
    .fifo_wr_en      (fifo_wr_en),
    .fifo_wr_data    (fifo_wr_data),
    .fifo_commit_ptr (fifo_commit_ptr),
    .fifo_rd_ptr     (fifo_rd_ptr),
    .wr_ptr_q        (wr_ptr_q),
    .state_q         (state_q),
    .cyc_valid       (cyc_valid)
);

// File: tb/test_pkt_rx_filter.sv
module test_pkt_rx_filter;

    localparam int          AW    = 5;
    localparam int          DEPTH = 1 << AW;
    localparam logic [15:0] NODE  = 16'hFFC2;
    localparam logic [15:0] OTHER = 16'h0123;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic          rx_sop = 1'b0;
    logic [31:0]   rx_data = '0;
    logic [AW:0]   rd_ptr = '0;
    logic          fifo_wr_en;
    logic [AW-1:0] fifo_wr_addr;
    logic [31:0]   fifo_wr_data;
    logic [AW:0]   fifo_commit_ptr;
    logic          cyc_valid;
    logic [31:0]   cyc_time;

    pkt_rx_filter #(.AW(AW)) i_pkt_rx_filter (
        .clk             (clk),
        .rst_n           (rst_n),
        .node_id         (NODE),
        .rx_valid        (rx_valid),
        .rx_sop          (rx_sop),
        .rx_data         (rx_data),
        .fifo_rd_ptr     (rd_ptr),
        .fifo_wr_en      (fifo_wr_en),
        .fifo_wr_addr    (fifo_wr_addr),
        .fifo_wr_data    (fifo_wr_data),
        .fifo_commit_ptr (fifo_commit_ptr),
        .cyc_valid       (cyc_valid),
        .cyc_time        (cyc_time)
    );

    always #10 clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    int          wr_cnt = 0;
    int          cyc_cnt = 0;
    logic [31:0] cyc_seen = '0;
    logic [31:0] mem [0:DEPTH-1];
    logic [31:0] pk [0:63];
    logic [AW:0] exp_commit = '0;

    // FIFO storage model and cycle-timer monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (fifo_wr_en) begin
            mem[fifo_wr_addr] = fifo_wr_data;
            wr_cnt++;
        end
        if (cyc_valid) begin
            cyc_cnt++;
            cyc_seen = cyc_time;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r;
        r = c;
        for (int b = 31; b >= 0; b--) begin
            logic fb;
            fb = r[31] ^ d[b];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ 32'h04C1_1DB7;
        end
        return r;
    endfunction

    task automatic drive(input logic v, input logic s, input logic [31:0] d);
        @(posedge clk);
        #5;
        rx_valid = v;
        rx_sop   = s;
        rx_data  = d;
    endtask

    // build, send and check one packet
    task automatic do_packet(input logic [15:0] dest, input logic [3:0] tc, input int len,
                             input bit bad_h, input bit bad_d, input logic [31:0] q3,
                             input bit stalls);
        int          hl, pay, n, cnt, cyc0;
        logic [31:0] c;
        bit          acc, fits, stored;
        logic [AW:0] base, used;
        string       lbl;
        hl  = (tc == 4'hA) ? 1 : 4;
        pay = ((tc == 4'h1) || (tc == 4'hA)) ? (len + 3) / 4 : 0;
        if (tc == 4'hA) begin
            pk[0] = {len[15:0], 2'b01, 6'd9, 4'hA, 4'h0};
        end else begin
            pk[0] = {dest, 6'd3, 2'b01, tc, 4'h0};
            pk[1] = 32'h0042_FFFF;
            pk[2] = $urandom;
            pk[3] = (tc == 4'h1) ? {len[15:0], 16'h0} : q3;
        end
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < hl; i++) c = crc_step(c, pk[i]);
        pk[hl] = ~c ^ {31'd0, bad_h};
        n = hl + 1;
        if (pay > 0) begin
            c = 32'hFFFF_FFFF;
            for (int i = 0; i < pay; i++) begin
                pk[n] = $urandom;
                c = crc_step(c, pk[n]);
                n++;
            end
            pk[n] = ~c ^ {31'd0, bad_d};
            n++;
        end
        acc    = (tc == 4'hA) || (dest == NODE) || (dest == 16'hFFFF);
        cnt    = hl + pay + 1;
        used   = exp_commit - rd_ptr;
        fits   = cnt <= (DEPTH - int'(used));
        stored = acc && !bad_h && fits;
        base   = exp_commit;
        cyc0   = cyc_cnt;
        for (int i = 0; i < n; i++) begin
            if (stalls && (i > 0)) begin
                while ($urandom % 4 == 0) drive(1'b0, 1'b0, $urandom);
            end
            drive(1'b1, i == 0, pk[i]);
        end
        repeat (3) drive(1'b0, 1'b0, 32'd0);
        if (stored) exp_commit = exp_commit + (AW+1)'(cnt);
        if (!acc)       lbl = "R1 commit pointer (rejected)";
        else if (bad_h) lbl = "R3 commit pointer (bad header CRC)";
        else if (!fits) lbl = "R8 commit pointer (FIFO full)";
        else            lbl = "R7 commit pointer advance";
        check(lbl, 32'(fifo_commit_ptr), 32'(exp_commit));
        if (stored) begin
            for (int i = 0; i < hl; i++)
                check("R4 header quadlet", mem[AW'(int'(base) + i)], pk[i]);
            for (int p = 0; p < pay; p++)
                check("R5 payload quadlet", mem[AW'(int'(base) + hl + p)], pk[hl + 1 + p]);
            check("R6 status quadlet", mem[AW'(int'(base) + hl + pay)],
                  {28'd0, ((pay > 0) && bad_d) ? 4'hD : 4'h1});
        end
        if ((tc == 4'h8) && acc && !bad_h) begin
            check("R9 cycle pulse count", 32'(cyc_cnt), 32'(cyc0 + 1));
            check("R9 cycle timer data", cyc_seen, q3);
        end else begin
            check("R9 no cycle pulse", 32'(cyc_cnt), 32'(cyc0));
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0;
        void'($urandom(32'd1394));
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        @(negedge clk);
        check("R10 commit pointer after reset", 32'(fifo_commit_ptr), 32'd0);
        check("R10 write strobe after reset", 32'(fifo_wr_en), 32'd0);
        check("R10 cycle strobe after reset", 32'(cyc_valid), 32'd0);

        // R11: stray quadlets without start marker
        w0 = wr_cnt;
        repeat (4) drive(1'b1, 1'b0, {NODE, 16'h0000});
        repeat (2) drive(1'b0, 1'b0, 32'd0);
        check("R11 stray quadlets not written", 32'(wr_cnt), 32'(w0));
        check("R11 commit unchanged", 32'(fifo_commit_ptr), 32'(exp_commit));

        // directed cases
        do_packet(NODE,   4'h0, 0, 0, 0, 32'hCAFE_0001, 0);  // R2 quadlet packet
        rd_ptr = exp_commit;
        do_packet(OTHER,  4'h0, 0, 0, 0, 32'h1111_2222, 0);  // R1 reject
        do_packet(NODE,   4'h1, 0, 0, 0, 32'd0, 0);          // R5 zero length
        rd_ptr = exp_commit;
        do_packet(NODE,   4'h1, 5, 0, 0, 32'd0, 1);          // R5 round up to 2
        rd_ptr = exp_commit;
        do_packet(NODE,   4'h1, 12, 1, 0, 32'd0, 0);         // R3 bad header CRC
        do_packet(16'hFFFF, 4'h1, 16, 0, 1, 32'd0, 1);       // R6 broadcast, bad data
        rd_ptr = exp_commit;
        do_packet(16'hFFFF, 4'h8, 0, 0, 0, 32'h0123_4ABC, 0); // R9 cycle start
        rd_ptr = exp_commit;
        do_packet(16'hFFFF, 4'h8, 0, 1, 0, 32'h0999_0001, 0); // R9 bad header CRC
        do_packet(NODE,   4'hA, 24, 0, 0, 32'd0, 1);         // R2 isochronous
        rd_ptr = exp_commit;
        // R8: only 4 free quadlets, a 5-quadlet packet must roll back
        rd_ptr = exp_commit - (AW+1)'(DEPTH - 4);
        do_packet(NODE,   4'h0, 0, 0, 0, 32'hBEEF_0000, 0);
        rd_ptr = exp_commit;
        do_packet(NODE,   4'h0, 0, 0, 0, 32'hBEEF_0001, 0);  // lands at rolled-back address
        rd_ptr = exp_commit;

        // constrained random traffic
        for (int k = 0; k < 60; k++) begin
            int kind;
            kind = int'($urandom % 8);
            case (kind)
                0: do_packet(NODE,     4'h0, 0, 0, 0, $urandom, 1);
                1: do_packet(OTHER,    4'h1, 8, 0, 0, 32'd0, 1);
                2: do_packet(NODE,     4'h1, int'($urandom % 61), 0, 0, 32'd0, 1);
                3: do_packet(16'hFFFF, 4'h1, int'($urandom % 61), 0, $urandom % 2, 32'd0, 1);
                4: do_packet(OTHER,    4'hA, int'($urandom % 61), 0, $urandom % 2, 32'd0, 1);
                5: do_packet(16'hFFFF, 4'h8, 0, $urandom % 2, 0, $urandom, 1);
                6: do_packet(NODE,     4'h1, 1 + int'($urandom % 60), 0, 1, 32'd0, 1);
                default: do_packet(NODE, 4'h1, int'($urandom % 61), 1, 0, 32'd0, 1);
            endcase
            rd_ptr = exp_commit;
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule